// File: doc/BRIEF.md
# Serial-Programmed Trim Register with Non-Volatile Backing

This block is a two-wire serial slave that owns a 7-bit calibration word for a current-sink DAC. A host writes the word over the bus and can read it back. The block adds one to the stored word, so the DAC sees a step code from 1 to 128. The word also has a copy in non-volatile storage. The block fills the working register from that copy when it leaves reset, and again whenever the write-protect input drops from high to low.

A write that ends with a STOP while write-protect is high starts a program cycle. The block sends one program pulse to the storage, then stays busy for a fixed number of clock cycles. During that time it refuses its own address. If write-protect falls during this time, the reload waits until the busy time is over.

The bus lines are sampled by the system clock, which must run at least 20 times faster than the bus clock. Each line goes through a two-flop synchroniser and then a run-length filter. The filter removes short spikes.

Top module: `nvtrim_ctrl_top`

## Requirements
- R1: After reset is released, the register takes the value on `nv_rd_data` within 3 clock cycles, and `nv_load_req` pulses once for one cycle.
- R2: The block answers an address byte whose bits 7:3 are 10011, whose bit 2 equals `addr_sel`, and whose bit 0 is R/W (1 = read). Bit 1 is ignored.
- R3: In a write, the data byte that follows the address loads its bits 6:0 into `trim_q`, and the block ACKs it. Bit 7 of that byte is ignored.
- R4: In a read, the block returns one byte with bits 6:0 equal to `trim_q` and bit 7 equal to 0, sent MSB first. It sends the byte again after each master ACK, and stops after a master NACK.
- R5: If the address does not match, the block never drives SDA and `trim_q` does not change.
- R6: A write transaction that ends in STOP while `wp_n` is high gives one `nv_prog_req` pulse carrying the new value. `busy` is then high for exactly PROG_CYCLES clock cycles.
- R7: While `wp_n` is low, a write still updates `trim_q` but gives no `nv_prog_req`.
- R8: While `busy` is high, the block NACKs its own address, and `trim_q` keeps its value.
- R9: A falling edge on `wp_n` reloads `trim_q` from `nv_rd_data` and pulses `nv_load_req`. If `busy` is high, this reload waits until `busy` falls.
- R10: `dac_code` always equals `trim_q` + 1, which ranges from 1 to 128.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_LEN clock cycles after the synchroniser has no effect on the bus protocol.
- R12: Only one data byte is accepted per write. Any further byte in the same transaction is NACKed and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | Pulls SDA low when 1 (open-drain enable) |
| addr_sel | input | 1 | Selects address bit 2 |
| wp_n | input | 1 | Write protect, active low; high allows programming |
| nv_rd_data | input | 7 | Current contents of non-volatile storage |
| nv_load_req | output | 1 | One-cycle pulse when the register takes `nv_rd_data` |
| nv_prog_req | output | 1 | One-cycle pulse that programs storage |
| nv_prog_data | output | 7 | Value to program, valid with `nv_prog_req` |
| trim_q | output | 7 | Working calibration register |
| dac_code | output | 8 | DAC step code, `trim_q` + 1 |
| busy | output | 1 | Program cycle in progress |

## Verification
The bench goes after these cases:

- **Program cycle refusal.** A new address arrives during the program cycle. A design that ACKs it would let a write disturb programming.
- **Deferred reload.** `wp_n` falls while `busy` is high. A design that reloads at once would capture storage contents that are about to change. The bench changes the storage model during `busy` so that an early reload shows up as a wrong value.
- **Busy length.** The bench measures the busy window to the exact cycle.
- **Extra byte.** A design that accepts a second data byte would overwrite the register.
- **SCL spike.** A two-cycle spike on SCL, placed inside a data byte, would add a bit and corrupt the value if the filter were missing or too short.
- **Bit 7 masking.** A design that drops the masking of bit 7 shows up as a wrong read-back value.

// File: rtl/nvtrim_pkg.sv
// Package: shared constants and the bus state type for the trim controller.
package nvtrim_pkg;
    // Fixed upper five bits of the slave address byte
    localparam logic [4:0] DEV_PREFIX = 5'b10011;
    localparam int         BYTE_W     = 8;

    typedef enum logic [2:0] {
        S_IDLE, // no transaction for us
        S_ADDR, // shifting the address byte
        S_AACK, // driving ACK for the address
        S_WR,   // shifting the data byte of a write
        S_WACK, // driving ACK for the data byte
        S_RD,   // sending the register byte
        S_RACK, // sampling the master ACK/NACK
        S_SKIP  // ignore the bus until START or STOP
    } bus_state_t;
endpackage

// File: rtl/nvtrim_line_filter.sv
// Module: two-flop synchroniser followed by a run-length spike filter.
// The output follows the input only after the synchronised input has
// differed from it for FILT_LEN consecutive cycles.
// Assumes the bus is idle high at reset.
module nvtrim_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] run;

    // Synchronise the line, then accept a change after a long enough run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            line_o <= 1'b1;
            run    <= '0;
        end else begin
            s1 <= line_i;
            s2 <= s1;
            if (s2 == line_o) begin
                run <= '0;
            end else if (run == CW'(FILT_LEN - 1)) begin
                line_o <= s2;
                run    <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    // R11: a filtered change always comes from the synchronised input
    // R11
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> (line_o == $past(s2)));
endmodule

// File: rtl/nvtrim_bus_slave.sv
// Module: byte-level two-wire slave. Detects START and STOP, matches the
// address, takes one data byte and returns the register on reads.
// Assumes filtered SCL/SDA with the same delay on both lines.
module nvtrim_bus_slave
    import nvtrim_pkg::*;
#(
    parameter int TRIM_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic              addr_sel,
    input  logic              busy,
    input  logic [TRIM_W-1:0] trim_q,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [TRIM_W-1:0] wr_data,
    output logic              commit
);
    bus_state_t        st;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh, tx, rd_byte;
    logic              rw, pend, mack, scl_p, sda_p;
    logic              rise, fall, start, stop, addr_hit;

    assign rise     = scl_f & ~scl_p;
    assign fall     = ~scl_f & scl_p;
    assign start    = scl_f & scl_p & sda_p & ~sda_f;
    assign stop     = scl_f & scl_p & ~sda_p & sda_f;
    assign addr_hit = (sh[7:3] == DEV_PREFIX) && (sh[2] == addr_sel) && !busy;
    assign rd_byte  = {{(BYTE_W-TRIM_W){1'b0}}, trim_q};

    // Bus protocol sequencer: shifts on SCL rise, drives SDA after SCL fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;  cnt <= '0;  sh <= '0;  tx <= '0;
            rw <= 1'b0;    pend <= 1'b0;  mack <= 1'b0;
            scl_p <= 1'b1; sda_p <= 1'b1; sda_oe <= 1'b0;
            wr_stb <= 1'b0; wr_data <= '0; commit <= 1'b0;
        end else begin
            scl_p  <= scl_f;
            sda_p  <= sda_f;
            wr_stb <= 1'b0;
            commit <= 1'b0;
            if (start) begin
                st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; pend <= 1'b0;
            end else if (stop) begin
                st <= S_IDLE; sda_oe <= 1'b0; commit <= pend; pend <= 1'b0;
            end else begin
                case (st)
                    S_ADDR: begin
                        if (rise) begin
                            sh  <= {sh[6:0], sda_f};
                            cnt <= cnt + 1'b1;
                        end else if (fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (addr_hit) begin
                                sda_oe <= 1'b1; rw <= sh[0]; st <= S_AACK;
                            end else begin
                                st <= S_SKIP;
                            end
                        end
                    end
                    S_AACK: begin
                        if (fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx <= rd_byte; sda_oe <= ~rd_byte[7]; st <= S_RD;
                            end else begin
                                sda_oe <= 1'b0; st <= S_WR;
                            end
                        end
                    end
                    S_WR: begin
                        if (rise) begin
                            sh  <= {sh[6:0], sda_f};
                            cnt <= cnt + 1'b1;
                        end else if (fall && cnt == 4'd8) begin
                            wr_stb <= 1'b1; wr_data <= sh[TRIM_W-1:0];
                            pend <= 1'b1; sda_oe <= 1'b1; st <= S_WACK;
                        end
                    end
                    S_WACK: begin
                        if (fall) begin
                            sda_oe <= 1'b0; st <= S_SKIP;
                        end
                    end
                    S_RD: begin
                        if (fall) begin
                            if (cnt == 4'd7) begin
                                sda_oe <= 1'b0; st <= S_RACK;
                            end else begin
                                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    S_RACK: begin
                        if (rise) begin
                            mack <= ~sda_f;
                        end else if (fall) begin
                            if (mack) begin
                                tx <= rd_byte; sda_oe <= ~rd_byte[7];
                                cnt <= '0; st <= S_RD;
                            end else begin
                                st <= S_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: the slave never starts pulling SDA while SCL is high
    // R4
    sda_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && scl_p) |-> !$rose(sda_oe));

    // R8: no data byte is taken while a program cycle runs
    // R8
    no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !busy);
endmodule

// File: rtl/nvtrim_store.sv
// Module: working register, restore from storage and program-cycle timer.
// Restores at reset exit and on a write-protect fall (deferred while busy).
// Commits on request when write-protect is high and idle.
module nvtrim_store #(
    parameter int TRIM_W      = 7,
    parameter int PROG_CYCLES = 5_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wr_stb,
    input  logic [TRIM_W-1:0] wr_data,
    input  logic              commit,
    input  logic [TRIM_W-1:0] nv_rd_data,
    output logic [TRIM_W-1:0] trim_q,
    output logic              nv_load_req,
    output logic              nv_prog_req,
    output logic [TRIM_W-1:0] nv_prog_data,
    output logic              busy
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] timer;
    logic          wp_s1, wp_s2, wp_s3, boot, reload_pend;
    logic          wp_fall, idle, take_nv, prog_ok;

    assign idle    = (timer == '0);
    assign busy    = !idle;
    assign wp_fall = wp_s3 & ~wp_s2;
    assign take_nv = boot || ((reload_pend || wp_fall) && idle);
    assign prog_ok = commit && wp_s2 && idle && !take_nv;

    // Register update, restore and program timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer <= '0; wp_s1 <= 1'b0; wp_s2 <= 1'b0; wp_s3 <= 1'b0;
            boot <= 1'b1; reload_pend <= 1'b0; trim_q <= '0;
            nv_load_req <= 1'b0; nv_prog_req <= 1'b0; nv_prog_data <= '0;
        end else begin
            wp_s1 <= wp_n; wp_s2 <= wp_s1; wp_s3 <= wp_s2;
            nv_load_req <= 1'b0;
            nv_prog_req <= 1'b0;
            if (!idle) timer <= timer - 1'b1;
            if (wp_fall) reload_pend <= 1'b1;
            if (take_nv) begin
                trim_q <= nv_rd_data; nv_load_req <= 1'b1;
                boot <= 1'b0; reload_pend <= 1'b0;
            end else if (wr_stb) begin
                trim_q <= wr_data;
            end
            if (prog_ok) begin
                nv_prog_req <= 1'b1; nv_prog_data <= trim_q;
                timer <= TW'(PROG_CYCLES);
            end
        end
    end

    // R6: programming only follows a cycle where write-protect was high
    // R6
    prog_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_prog_req |-> $past(wp_s2));

    // R9: no reload while the program cycle runs
    // R9
    no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !nv_load_req);

    // R8: the register holds still through a program cycle
    // R8
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(trim_q));
endmodule

// File: rtl/nvtrim_ctrl_top.sv
// Module: top of the trim controller. Filters the bus lines, runs the
// slave and the store, and forms the DAC code as register plus one.
// Assumes clk is at least 20x the SCL rate.
module nvtrim_ctrl_top #(
    parameter int TRIM_W      = 7,
    parameter int FILT_LEN    = 3,
    parameter int PROG_CYCLES = 5_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_sel,
    input  logic              wp_n,
    input  logic [TRIM_W-1:0] nv_rd_data,
    output logic              nv_load_req,
    output logic              nv_prog_req,
    output logic [TRIM_W-1:0] nv_prog_data,
    output logic [TRIM_W-1:0] trim_q,
    output logic [TRIM_W:0]   dac_code,
    output logic              busy
);
    logic [1:0]        raw, filt;
    logic              wr_stb, commit;
    logic [TRIM_W-1:0] wr_data;

    assign raw = {scl_i, sda_i};

    // One filter per bus line (bit 1 = SCL, bit 0 = SDA)
    for (genvar g = 0; g < 2; g++) begin : g_filt
        nvtrim_line_filter #(.FILT_LEN(FILT_LEN)) filt_i (
            .clk(clk), .rst_n(rst_n), .line_i(raw[g]), .line_o(filt[g]));
    end

    nvtrim_bus_slave #(.TRIM_W(TRIM_W)) slave_i (
        .clk(clk), .rst_n(rst_n), .scl_f(filt[1]), .sda_f(filt[0]),
        .addr_sel(addr_sel), .busy(busy), .trim_q(trim_q), .sda_oe(sda_oe),
        .wr_stb(wr_stb), .wr_data(wr_data), .commit(commit));

    nvtrim_store #(.TRIM_W(TRIM_W), .PROG_CYCLES(PROG_CYCLES)) store_i (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wr_stb(wr_stb),
        .wr_data(wr_data), .commit(commit), .nv_rd_data(nv_rd_data),
        .trim_q(trim_q), .nv_load_req(nv_load_req), .nv_prog_req(nv_prog_req),
        .nv_prog_data(nv_prog_data), .busy(busy));

    // DAC step code is the register plus one (1..2^TRIM_W)
    assign dac_code = {1'b0, trim_q} + 1'b1;
endmodule

// File: tb/nvtrim_ctrl_top_tb_top.sv
// Bench: directed scenarios on the trim controller with a storage model.
module nvtrim_ctrl_top_tb_top;
    localparam int P = 2000;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1, sda_drv = 1'b1;
    logic       addr_sel = 1'b1, wp_n = 1'b0;
    logic       sda_oe, nv_load_req, nv_prog_req, busy, sda_line;
    logic [6:0] nv_prog_data, trim_q, nv_mem = 7'h2A, nv_force_val = '0;
    logic       nv_force = 1'b0;
    logic [7:0] dac_code;
    int         errors = 0, checks = 0, prog_cnt = 0, load_cnt = 0, busy_cyc = 0;

    always #10 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    nvtrim_ctrl_top #(.TRIM_W(7), .FILT_LEN(3), .PROG_CYCLES(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .wp_n(wp_n),
        .nv_rd_data(nv_mem), .nv_load_req(nv_load_req),
        .nv_prog_req(nv_prog_req), .nv_prog_data(nv_prog_data),
        .trim_q(trim_q), .dac_code(dac_code), .busy(busy));

    // Storage model and port-level event counters
    always @(posedge clk) begin
        if (nv_prog_req) nv_mem <= nv_prog_data;
        else if (nv_force) nv_mem <= nv_force_val;
        if (nv_prog_req) prog_cnt <= prog_cnt + 1;
        if (nv_load_req) load_cnt <= load_cnt + 1;
        if (busy) busy_cyc <= busy_cyc + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(Q);
    endtask

    // Send a byte; glitch_bit >= 0 inserts a 2-cycle SCL spike after that bit
    task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wq(Q);
            scl_drv = 1'b1; wq(2 * Q);
            scl_drv = 1'b0;
            if (i == glitch_bit) begin
                wq(3); scl_drv = 1'b1; wq(2); scl_drv = 1'b0; wq(Q - 5);
            end else begin
                wq(Q);
            end
        end
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = 1'b1; wq(Q);
            scl_drv = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl_drv = 1'b0; wq(Q);
        end
        sda_drv = ~mack; wq(Q);
        scl_drv = 1'b1; wq(2 * Q);
        scl_drv = 1'b0; wq(Q);
        sda_drv = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int gb,
                            output logic aa, output logic da);
        bus_start();
        send_byte(a, -1, aa);
        if (aa) send_byte(d, gb, da); else da = 1'b0;
        bus_stop();
        wq(10);
    endtask

    task automatic t_reset();
        wq(5); rst_n = 1'b1; wq(6);
        chk("R1 trim after reset", trim_q, 7'h2A);
        chk("R1 load pulses", load_cnt, 1);
        chk("R10 dac code", dac_code, 8'h2B);
        chk("R1 idle outputs", {busy, sda_oe}, 2'b00);
    endtask

    task automatic t_write_read();
        logic aa, da, ra; logic [7:0] rb; int pc;
        pc = prog_cnt;
        do_write(8'h9C, 8'h85, -1, aa, da);
        chk("R3 addr ack", aa, 1'b1);
        chk("R3 data ack", da, 1'b1);
        chk("R3 bit7 masked", trim_q, 7'h05);
        chk("R10 dac code", dac_code, 8'h06);
        chk("R7 no program with wp low", prog_cnt, pc);
        bus_start(); send_byte(8'h9D, -1, ra); read_byte(1'b0, rb); bus_stop();
        chk("R4 read ack", ra, 1'b1);
        chk("R4 read value", rb, 8'h05);
        bus_start(); send_byte(8'h9F, -1, ra); read_byte(1'b1, rb);
        chk("R4 first byte", rb, 8'h05);
        read_byte(1'b0, rb); bus_stop();
        chk("R2 bit1 ignored ack", ra, 1'b1);
        chk("R4 repeat after master ack", rb, 8'h05);
    endtask

    task automatic t_addr();
        logic aa, da; int oe_seen;
        oe_seen = 0;
        fork
            do_write(8'h98, 8'h11, -1, aa, da);
            repeat (700) begin @(negedge clk); if (sda_oe) oe_seen++; end
        join
        chk("R5 wrong address nack", aa, 1'b0);
        chk("R5 sda never driven", oe_seen, 0);
        chk("R5 trim unchanged", trim_q, 7'h05);
        addr_sel = 1'b0;
        do_write(8'h98, 8'h12, -1, aa, da);
        chk("R2 addr_sel low ack", aa, 1'b1);
        chk("R2 write with addr_sel low", trim_q, 7'h12);
    endtask

    task automatic t_commit();
        logic aa, da; int pc;
        wp_n = 1'b1; wq(10);
        pc = prog_cnt; busy_cyc = 0;
        do_write(8'h98, 8'h7F, -1, aa, da);
        chk("R6 one program pulse", prog_cnt, pc + 1);
        chk("R6 storage written", nv_mem, 7'h7F);
        chk("R6 busy after commit", busy, 1'b1);
        do_write(8'h98, 8'h01, -1, aa, da);
        chk("R8 nack while busy", aa, 1'b0);
        chk("R8 trim held while busy", trim_q, 7'h7F);
        while (busy) @(negedge clk);
        wq(2);
        chk("R6 busy length", busy_cyc, P);
        chk("R6 no extra program", prog_cnt, pc + 1);
    endtask

    task automatic t_wp_reload();
        logic aa, da; int lc, pc;
        lc = load_cnt; pc = prog_cnt;
        wp_n = 1'b0; wq(10);
        chk("R9 reload on wp fall", load_cnt, lc + 1);
        do_write(8'h98, 8'h11, -1, aa, da);
        chk("R7 volatile write with wp low", trim_q, 7'h11);
        chk("R7 no program with wp low", prog_cnt, pc);
        wp_n = 1'b1; wq(10);
        wp_n = 1'b0; wq(10);
        chk("R9 reload restores storage", trim_q, 7'h7F);
        chk("R9 load pulse count", load_cnt, lc + 2);
        wp_n = 1'b1; wq(10);
        do_write(8'h98, 8'h33, -1, aa, da);
        chk("R6 busy for deferred test", busy, 1'b1);
        nv_force_val = 7'h44; nv_force = 1'b1; @(negedge clk); nv_force = 1'b0;
        lc = load_cnt;
        wp_n = 1'b0; wq(20);
        chk("R9 reload deferred value", trim_q, 7'h33);
        chk("R9 no load while busy", load_cnt, lc);
        while (busy) @(negedge clk);
        wq(3);
        chk("R9 deferred reload value", trim_q, 7'h44);
        chk("R9 deferred load pulse", load_cnt, lc + 1);
    endtask

    task automatic t_glitch_extra();
        logic aa, da, a2; logic [7:0] rb;
        do_write(8'h98, 8'h5A, 3, aa, da);
        chk("R11 ack with scl spike", da, 1'b1);
        chk("R11 value with scl spike", trim_q, 7'h5A);
        bus_start();
        send_byte(8'h98, -1, aa); send_byte(8'h22, -1, da); send_byte(8'h55, -1, a2);
        bus_stop(); wq(10);
        chk("R12 first byte ack", da, 1'b1);
        chk("R12 second byte nack", a2, 1'b0);
        chk("R12 second byte ignored", trim_q, 7'h22);
        bus_start(); send_byte(8'h99, -1, aa); read_byte(1'b0, rb); bus_stop();
        chk("R4 read after extra byte", rb, 8'h22);
    endtask

    function automatic void summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_write_read();
        t_addr();
        t_commit();
        t_wp_reload();
        t_glitch_extra();
        summary();
        $finish;
    end
endmodule